// File: doc/BRIEF.md
# Serial-Input Latched Display Line Driver

This block is the digital control side of a cascadable display driver. A serial bit stream is clocked into a 20-stage shift register by an external shift clock. The bit in the last stage is presented on a serial output, so a second device can take it as its own serial input and several devices can be chained. A strobe input transfers the register into a bank of output latches.

The latches are level-transparent. While strobe is high they follow the register, and while strobe is low they hold their contents. Each latch bit drives one display line through a pair of complementary controls: a source enable and a pull-down enable. An active-high blanking input switches every line to its pull-down state and leaves the latch contents untouched.

The shift clock, serial data, strobe and blanking inputs are all asynchronous to the fast system clock. Each passes through a two-flop synchronizer. Shift-clock rising edges are detected in the system clock domain, so the system clock must run at least four times faster than the shift clock.

Top module: `serial_display_driver`

## Requirements
- R1: On each detected rising edge of `shift_clk`, the synchronized `ser_in` value is stored in register stage 0, the stage nearest the serial input.
- R2: On each detected rising edge, every stage i takes the value of stage i-1. `ser_out` always carries stage 19, the last stage.
- R3: While the synchronized strobe is high, the latches take the register value every system clock cycle. If a shift edge occurs in the same cycle, they take the value after the shift.
- R4: While the synchronized strobe is low, the latches keep their value, whatever shifting takes place.
- R5: While the synchronized blanking is high, every `src_en` bit is 0 and every `pd_en` bit is 1, whatever the latches hold.
- R6: Blanking does not alter the latch contents. After blanking returns low, each line again follows its own latch.
- R7: With strobe held high and blanking held high during serial entry, no `src_en` bit is 1 at any point during the entry. Once blanking drops, the lines show the final shifted pattern.
- R8: In every cycle, `pd_en` is the exact bitwise complement of `src_en`.
- R9: A synchronous active-low reset clears the register, the latches and the synchronizers. After reset, `src_en` is all 0, `pd_en` is all 1 and `ser_out` is 0.
- R10: Latch bit i drives line i (`src_en[i]`, `pd_en[i]`). After 20 shifts, the first bit shifted in sits on line 19.
- R11: A blanking change at the port reaches the lines on the second system clock edge after it. A shift-clock rise or a strobe change takes effect on the register or latches on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Asynchronous shift clock; rising edge shifts |
| ser_in | input | 1 | Serial data input |
| strobe | input | 1 | Latch transparency control, active high |
| blank | input | 1 | Blanking, active high |
| ser_out | output | 1 | Last register stage, for cascading |
| src_en | output | 20 | Per-line source enable |
| pd_en | output | 20 | Per-line pull-down enable |

## Verification
The hardest case to reach from the ports is a shift edge that lands in the same system clock cycle as a high strobe. Here the latches must take the post-shift value, not the old one. The bench gets there by raising `shift_clk` and `strobe` on the same clock. The two inputs then pass through matched synchronizers and arrive together. The bench also runs the transparent-latch entry case with blanking high and watches every cycle for a stray source enable.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Rising-edge detector term for a synchronized level.
  function automatic logic rise_seen(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  // Source enable for one line given its latch bit and blanking.
  function automatic logic src_drive(input logic bit_v, input logic blank_v);
    return bit_v & ~blank_v;
  endfunction

  // Pull-down enable for one line, written independently of src_drive.
  function automatic logic pd_drive(input logic bit_v, input logic blank_v);
    return ~bit_v | blank_v;
  endfunction

endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

  // R11: the synchronized output is the input delayed by the stage count
  a_r11_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (STAGES == 2)) |=> (dout == $past(stg[0])));
endmodule

// File: rtl/sdd_shift.sv
module sdd_shift
  import sdd_pkg::*;
#(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         data_s,
  output logic         shift_pulse,
  output logic [N-1:0] sreg,
  output logic [N-1:0] sreg_next
);
  logic sclk_prev;

  assign shift_pulse = rise_seen(sclk_s, sclk_prev);

  always_comb begin
    sreg_next = shift_pulse ? {sreg[N-2:0], data_s} : sreg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sreg      <= '0;
    end else begin
      sclk_prev <= sclk_s;
      sreg      <= sreg_next;
    end
  end

  // R1: captured bit lands in stage 0
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (sreg[0] == $past(data_s)));
  // R2: every stage moves one step toward the serial output
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (sreg[N-1:1] == $past(sreg[N-2:0])));
  // R2: no detected edge, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(sreg));
endmodule

// File: rtl/sdd_latch.sv
module sdd_latch #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_s,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] cur_reg,
  output logic [N-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        latch_q <= '0;
    else if (strobe_s) latch_q <= load_val;
  end

  // R3: with strobe high, latches equal the register after the edge (post-shift)
  a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_s |=> (latch_q == cur_reg));
  // R4, R6: strobe low keeps the latches, blanking or not
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_s |=> $stable(latch_q));
endmodule

// File: rtl/sdd_outdrv.sv
module sdd_outdrv
  import sdd_pkg::*;
#(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] latch_q,
  input  logic         blank_s,
  output logic [N-1:0] src_en,
  output logic [N-1:0] pd_en
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign src_en[g] = src_drive(latch_q[g], blank_s);
    assign pd_en[g]  = pd_drive(latch_q[g], blank_s);
  end

  // R5: blanking forces all lines to pull-down
  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank_s |-> ((src_en == '0) && (pd_en == '1)));
  // R8: the two enables of every line never agree
  a_r8_compl: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en ^ pd_en) == '1);
  // R6, R10: unblanked, line i follows latch bit i
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_s |-> (src_en == latch_q));
endmodule

// File: rtl/serial_display_driver.sv
module serial_display_driver #(
  parameter int N_LINES     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_clk,
  input  logic               ser_in,
  input  logic               strobe,
  input  logic               blank,
  output logic               ser_out,
  output logic [N_LINES-1:0] src_en,
  output logic [N_LINES-1:0] pd_en
);
  localparam int N_IN = 4;

  logic [N_IN-1:0]    raw_in, sync_in;
  logic               sclk_s, data_s, strobe_s, blank_s;
  logic               shift_pulse;
  logic [N_LINES-1:0] sreg, sreg_next, latch_q;

  assign raw_in = {blank, strobe, ser_in, shift_clk};
  assign {blank_s, strobe_s, data_s, sclk_s} = sync_in;

  sdd_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_in));

  sdd_shift #(.N(N_LINES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .data_s(data_s),
    .shift_pulse(shift_pulse), .sreg(sreg), .sreg_next(sreg_next));

  sdd_latch #(.N(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s),
    .load_val(sreg_next), .cur_reg(sreg), .latch_q(latch_q));

  sdd_outdrv #(.N(N_LINES)) u_out (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .blank_s(blank_s),
    .src_en(src_en), .pd_en(pd_en));

  assign ser_out = sreg[N_LINES-1];

  // R2: serial output tracks the previous last-but-one stage on a shift
  a_r2_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (ser_out == $past(sreg[N_LINES-2])));
  // R9: the cycle after reset, all lines sit in pull-down
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> ((src_en == '0) && (pd_en == '1) && !ser_out));
endmodule

// File: tb/sim_serial_display_driver.sv
`timescale 1ns/1ps
module sim_serial_display_driver;
  localparam int N = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift_clk = 1'b0, ser_in = 1'b0, strobe = 1'b0, blank = 1'b0;
  logic ser_out;
  logic [N-1:0] src_en, pd_en;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_display_driver u0 (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_in(ser_in),
    .strobe(strobe), .blank(blank), .ser_out(ser_out),
    .src_en(src_en), .pd_en(pd_en));

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: queues model the two-cycle input delay
  bit q_ck[$], q_d[$], q_st[$], q_bl[$];
  int m_sr[N];
  int m_lat[N];
  bit m_ckp = 0;

  function automatic void model_clear();
    q_ck = '{0, 0}; q_d = '{0, 0}; q_st = '{0, 0}; q_bl = '{0, 0};
    foreach (m_sr[i]) begin m_sr[i] = 0; m_lat[i] = 0; end
    m_ckp = 0;
  endfunction

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
    end else begin
      if (q_ck[0] && !m_ckp) begin
        for (int i = N-1; i > 0; i--) m_sr[i] = m_sr[i-1];
        m_sr[0] = q_d[0];
      end
      if (q_st[0]) foreach (m_sr[i]) m_lat[i] = m_sr[i];
      m_ckp = q_ck[0];
      void'(q_ck.pop_front()); q_ck.push_back(shift_clk);
      void'(q_d.pop_front());  q_d.push_back(ser_in);
      void'(q_st.pop_front()); q_st.push_back(strobe);
      void'(q_bl.pop_front()); q_bl.push_back(blank);
    end
  end

  // Per-cycle comparison (R1 R2 R3 R4 R5 R6 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] e_src;
      for (int i = 0; i < N; i++) e_src[i] = (q_bl[0] == 0) && (m_lat[i] != 0);
      check("R1 R2 serial out", {{(N-1){1'b0}}, ser_out},
            {{(N-1){1'b0}}, m_sr[N-1] != 0});
      check("R3 R4 R5 src_en", src_en, e_src);
      check("R8 pd_en complement", pd_en, ~src_en);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_in = b;
    @(negedge clk); shift_clk = 1'b1;
    repeat (3) @(negedge clk);
    shift_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_word(input logic [N-1:0] w);
    for (int k = N-1; k >= 0; k--) shift_bit(w[k]);
  endtask

  logic [N-1:0] P = 20'hA5C3E, Q = 20'h3C96B, W = 20'hF0F1D;
  bit stray;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset src_en", src_en, '0);
    check("R9 reset pd_en", pd_en, '1);
    check("R9 reset ser_out", {{(N-1){1'b0}}, ser_out}, '0);

    // load P with strobe low: lines stay dark
    shift_word(P);
    check("R4 no strobe, lines unchanged", src_en, '0);
    check("R2 ser_out is first bit shifted", {{(N-1){1'b0}}, ser_out},
          {{(N-1){1'b0}}, P[N-1]});
    strobe = 1'b1; repeat (4) @(negedge clk);
    strobe = 1'b0; repeat (3) @(negedge clk);
    check("R3 R10 strobe transfers pattern", src_en, P);

    // shift Q with strobe low: held
    shift_word(Q);
    check("R4 latches hold during shifting", src_en, P);

    // blanking latency and effect
    blank = 1'b1;
    @(negedge clk);
    check("R11 blank not yet visible after one edge", src_en, P);
    @(negedge clk);
    check("R11 R5 blank forces src off", src_en, '0);
    check("R5 blank forces pull-down", pd_en, '1);
    repeat (3) @(negedge clk);
    blank = 1'b0; repeat (3) @(negedge clk);
    check("R6 latches kept through blanking", src_en, P);

    // shift edge and strobe together: post-shift value latched
    @(negedge clk); ser_in = 1'b1;
    @(negedge clk); shift_clk = 1'b1; strobe = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 strobe not yet effective after two edges", src_en, P);
    @(negedge clk);
    check("R1 R3 same-cycle strobe takes post-shift value", src_en,
          {Q[N-2:0], 1'b1});
    strobe = 1'b0; shift_clk = 1'b0; repeat (4) @(negedge clk);

    // transparent entry with blanking high
    blank = 1'b1; strobe = 1'b1; repeat (3) @(negedge clk);
    stray = 0;
    fork
      shift_word(W);
      begin
        for (int c = 0; c < N*8; c++) begin
          @(negedge clk); if (src_en != '0) stray = 1;
        end
      end
    join
    check("R7 no source enable during transparent entry",
          {{(N-1){1'b0}}, stray}, '0);
    blank = 1'b0; strobe = 1'b0; repeat (4) @(negedge clk);
    check("R7 R10 final pattern after unblank", src_en, W);

    // reset mid-operation
    rst_n = 1'b0; @(negedge clk); @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    check("R9 reset clears lines", src_en, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule